// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block is a memory-mapped pulse-width modulator with four independent output channels, reached through a plain register bus with an address, write data, a write strobe and combinational read data. Each channel has a control word, a duty count and a period count. Its control word holds a channel enable and a 14-bit prescale value. The prescaler divides the input clock before it reaches the channel's period counter.

A single chip-wide master enable gates every channel. A channel produces its pulse train only while both the master enable and its own enable are set. Software programs duty and period first, sets the channel enable, and then sets or already holds the master enable. Duty and period values written while a channel runs are held back until the current period ends, so no pulse is cut short or stretched.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads zero and all four outputs are low.
- R2: Channel n's registers sit at byte address n*0x10: control at offset 0x0 (bit 0 = channel enable, bits 15:2 = prescale), duty at offset 0x4 (bits 15:0) and period at offset 0x8 (bits 15:0). The master enable is bit 0 at address 0x3C. Each register reads back its last written value, bits with no field read as zero, and addresses with no register read zero.
- R3: A running channel repeats a pattern of (prescale+1)×period input clock cycles. The output is high for the first (prescale+1)×duty cycles of each pattern. It goes high in the first cycle after the write that starts the channel, and a duty of zero keeps it low.
- R4: When the duty value is greater than or equal to a nonzero period value, the output stays high for the whole period.
- R5: A channel's output is low whenever the master enable or the channel's own enable is clear.
- R6: Setting the master enable starts no channel whose own enable is clear.
- R7: Clearing either enable resets the channel's prescale and period counters, so a channel that is enabled again restarts at the beginning of a period.
- R8: Duty and period values written while a channel runs take effect at the next period boundary. Values written while it is stopped are used from the first period.
- R9: Channels run independently: two channels with different prescale, duty and period values, started by the same master-enable write, each produce their own pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, also the count clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Byte address of the register being read or written |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe, captured on the rising clock edge |
| rdata | output | 32 | Read data for the register at addr (combinational) |
| pwm_o | output | 4 | One pulse output per channel |

## Verification
The waveform is tried with a prescale of zero, where duty and period map directly to clock cycles, and with a prescale of two, which shows whether the divider stretches every period step and not only the first. Duty equal to and above the period separates a strict from a non-strict full-on comparison. Duty and period are rewritten a few cycles into a running period, which shows whether the new values wait for the boundary. Two channels started by one master write, each with its own settings, reveal any crosstalk between channels. Enable-only and master-only patterns separate the two gates.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
   // register offsets inside one channel window
   localparam logic [3:0] OFS_CTRL   = 4'h0;
   localparam logic [3:0] OFS_DUTY   = 4'h4;
   localparam logic [3:0] OFS_PERIOD = 4'h8;
   // bytes per channel window and master register address
   localparam int WIN_BYTES   = 16;
   localparam int MASTER_ADDR = 'h3C;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int PRE_W  = 14,
   parameter int CNT_W  = 16,
   parameter int AW     = 8,
   parameter int DW     = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [AW-1:0]                 addr,
   input  logic [DW-1:0]                 wdata,
   input  logic                          we,
   output logic                          master_en,
   output logic [NUM_CH-1:0]             ch_en,
   output logic [NUM_CH-1:0][PRE_W-1:0]  pre,
   output logic [NUM_CH-1:0][CNT_W-1:0]  duty,
   output logic [NUM_CH-1:0][CNT_W-1:0]  period,
   output logic [DW-1:0]                 rdata
);
   localparam logic [AW-1:0] A_MASTER = AW'(MASTER_ADDR);
   localparam int            PRE_LSB  = 2;
   localparam int            PRE_MSB  = PRE_LSB + PRE_W - 1;

   logic                         master_hit;
   logic [NUM_CH-1:0][DW-1:0]    rd_ch;
   logic                         unused_wdata;

   assign master_hit   = we && (addr == A_MASTER);
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n)          master_en <= 1'b0;
      else if (master_hit) master_en <= wdata[0];
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam logic [AW-1:0] A_CTRL = AW'(c*WIN_BYTES + int'(OFS_CTRL));
      localparam logic [AW-1:0] A_DUTY = AW'(c*WIN_BYTES + int'(OFS_DUTY));
      localparam logic [AW-1:0] A_PER  = AW'(c*WIN_BYTES + int'(OFS_PERIOD));

      logic             en_q;
      logic [PRE_W-1:0] pre_q;
      logic [CNT_W-1:0] duty_q;
      logic [CNT_W-1:0] per_q;
      logic [DW-1:0]    rd_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_q   <= 1'b0;
            pre_q  <= '0;
            duty_q <= '0;
            per_q  <= '0;
         end else if (we) begin
            if (addr == A_CTRL) begin
               en_q  <= wdata[0];
               pre_q <= wdata[PRE_MSB:PRE_LSB];
            end
            if (addr == A_DUTY) duty_q <= wdata[CNT_W-1:0];
            if (addr == A_PER)  per_q  <= wdata[CNT_W-1:0];
         end
      end

      always_comb begin
         rd_q = '0;
         if (addr == A_CTRL) begin
            rd_q[0]               = en_q;
            rd_q[PRE_MSB:PRE_LSB] = pre_q;
         end else if (addr == A_DUTY) begin
            rd_q[CNT_W-1:0] = duty_q;
         end else if (addr == A_PER) begin
            rd_q[CNT_W-1:0] = per_q;
         end
      end

      assign ch_en[c]  = en_q;
      assign pre[c]    = pre_q;
      assign duty[c]   = duty_q;
      assign period[c] = per_q;
      assign rd_ch[c]  = rd_q;

      // R2: a control write is visible on the next cycle
      p_ctrl_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (we && addr == A_CTRL) |=> (ch_en[c] == $past(wdata[0])));
   end

   always_comb begin
      rdata = '0;
      if (addr == A_MASTER) rdata[0] = master_en;
      for (int c = 0; c < NUM_CH; c++) rdata = rdata | rd_ch[c];
   end

   // R2: master write lands in the master enable
   p_master_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      master_hit |=> (master_en == $past(wdata[0])));
endmodule

// File: rtl/pwm_bank_prescale.sv
module pwm_bank_prescale #(
   parameter int PRE_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] limit,
   output logic             tick
);
   logic [PRE_W-1:0] cnt;
   logic             at_lim;

   assign at_lim = (cnt >= limit);
   assign tick   = run && at_lim;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt <= '0;
      else if (!run || at_lim) cnt <= '0;
      else                     cnt <= cnt + 1'b1;
   end

   // R7: a stopped channel keeps its divider at zero
   p_pre_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan #(
   parameter int PRE_W  = 14,
   parameter int CNT_W  = 16,
   parameter bit SHADOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] pre,
   input  logic [CNT_W-1:0] duty,
   input  logic [CNT_W-1:0] period,
   output logic             pwm
);
   logic             tick;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] duty_use;
   logic [CNT_W-1:0] per_use;
   logic [CNT_W:0]   cnt_nxt;
   logic             wrap;
   logic             boundary;

   pwm_bank_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .limit (pre),
      .tick  (tick)
   );

   assign cnt_nxt  = {1'b0, cnt} + 1'b1;
   assign wrap     = (cnt_nxt >= {1'b0, per_use});
   assign boundary = tick && wrap;

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt <= '0;
      else if (!run)     cnt <= '0;
      else if (boundary) cnt <= '0;
      else if (tick)     cnt <= cnt_nxt[CNT_W-1:0];
   end

   if (SHADOW) begin : g_shadow
      logic [CNT_W-1:0] duty_sh;
      logic [CNT_W-1:0] per_sh;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            duty_sh <= '0;
            per_sh  <= '0;
         end else if (!run || boundary) begin
            duty_sh <= duty;
            per_sh  <= period;
         end
      end

      assign duty_use = duty_sh;
      assign per_use  = per_sh;

      // R8: working values hold inside a running period
      p_hold_mid_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (run && !boundary) |=> (duty_use == $past(duty_use) && per_use == $past(per_use)));
      // R3: the period counter stays below the working period
      p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (per_use != '0) |-> (cnt < per_use));
   end else begin : g_direct
      assign duty_use = duty;
      assign per_use  = period;
   end

   assign pwm = run && (cnt < duty_use);

   // R4: duty at or above a nonzero period keeps the output high
   p_full_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (SHADOW && run && per_use != '0 && duty_use >= per_use) |-> pwm);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int PRE_W  = 14,
   parameter int CNT_W  = 16,
   parameter int AW     = 8,
   parameter int DW     = 32,
   parameter bit SHADOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     addr,
   input  logic [DW-1:0]     wdata,
   input  logic              we,
   output logic [DW-1:0]     rdata,
   output logic [NUM_CH-1:0] pwm_o
);
   localparam int MASTER_WIN = MASTER_ADDR / WIN_BYTES;
   localparam int MASTER_OFS = MASTER_ADDR % WIN_BYTES;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least one");
   end
   if (NUM_CH * WIN_BYTES > (1 << AW) || MASTER_ADDR >= (1 << AW)) begin : g_bad_aw
      $error("AW too narrow for the register windows");
   end
   if (PRE_W + 2 > DW || CNT_W > DW) begin : g_bad_dw
      $error("DW too narrow for the register fields");
   end
   if (MASTER_WIN < NUM_CH && (MASTER_OFS == int'(OFS_CTRL) ||
       MASTER_OFS == int'(OFS_DUTY) || MASTER_OFS == int'(OFS_PERIOD))) begin : g_bad_map
      $error("master register collides with a channel register");
   end

   logic                         master_en;
   logic [NUM_CH-1:0]            ch_en;
   logic [NUM_CH-1:0][PRE_W-1:0] pre;
   logic [NUM_CH-1:0][CNT_W-1:0] duty;
   logic [NUM_CH-1:0][CNT_W-1:0] period;

   pwm_bank_regs #(
      .NUM_CH (NUM_CH),
      .PRE_W  (PRE_W),
      .CNT_W  (CNT_W),
      .AW     (AW),
      .DW     (DW)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (addr),
      .wdata     (wdata),
      .we        (we),
      .master_en (master_en),
      .ch_en     (ch_en),
      .pre       (pre),
      .duty      (duty),
      .period    (period),
      .rdata     (rdata)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      logic run;
      assign run = master_en && ch_en[c];

      pwm_bank_chan #(
         .PRE_W  (PRE_W),
         .CNT_W  (CNT_W),
         .SHADOW (SHADOW)
      ) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .run    (run),
         .pre    (pre[c]),
         .duty   (duty[c]),
         .period (period[c]),
         .pwm    (pwm_o[c])
      );

      // R5: either enable clear forces the output low
      p_gate_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
         !(master_en && ch_en[c]) |-> !pwm_o[c]);
      // R6: master alone starts nothing
      p_master_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (master_en && !ch_en[c]) |-> !pwm_o[c]);
   end

   // R1: outputs are low straight after reset
   p_reset_low_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (pwm_o == '0));
endmodule

// File: tb/pwm_bank_test.sv
module pwm_bank_test;
   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 4;
   localparam int NEVER      = 32'h3FFF_FFFF;

   typedef struct {
      int         cyc;
      logic [3:0] vec;
      string      tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        we = 1'b0;
   logic [31:0] rdata;
   logic [3:0]  pwm;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;
   item_t q[$];

   // reference configuration per channel
   int m_pre[NCH], m_d0[NCH], m_p0[NCH], m_d1[NCH], m_p1[NCH], m_st[NCH], m_sw[NCH];
   bit m_en[NCH];
   bit m_mst = 1'b0;

   pwm_bank uut (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (addr),
      .wdata (wdata),
      .we    (we),
      .rdata (rdata),
      .pwm_o (pwm)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   function automatic bit exp_bit(input int c, input int t);
      int kk, d, p, per;
      if (!(m_mst && m_en[c])) return 1'b0;
      kk = t - m_st[c];
      if (kk < 0) return 1'b0;
      if (kk >= m_sw[c]) begin
         kk = kk - m_sw[c]; d = m_d1[c]; p = m_p1[c];
      end else begin
         d = m_d0[c]; p = m_p0[c];
      end
      if (p == 0) p = 1;
      per = (kk / (m_pre[c] + 1)) % p;
      return per < d;
   endfunction

   // driver side of the scoreboard
   task automatic expect_span(input int from, input int n, input string tag);
      for (int k = 0; k < n; k++) begin
         item_t it;
         it.cyc = from + k;
         for (int c = 0; c < NCH; c++) it.vec[c] = exp_bit(c, from + k);
         it.tag = tag;
         q.push_back(it);
      end
   endtask

   task automatic drain();
      wait (q.size() == 0);
      @(posedge clk); #2;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, output int m);
      @(posedge clk); #2;
      addr = a; wdata = d; we = 1'b1;
      m = cyc;
      @(posedge clk); #2;
      we = 1'b0;
   endtask

   task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string req);
      @(posedge clk); #2;
      addr = a;
      #1 check(req, rdata, exp);
   endtask

   task automatic cfg_ch(input int c, input int pre, input int d, input int p, input bit en);
      int m;
      logic [7:0] base;
      base = 8'(c * 16);
      wr(base + 8'h4, 32'(d), m);
      wr(base + 8'h8, 32'(p), m);
      wr(base, 32'((pre << 2) | int'(en)), m);
      m_pre[c] = pre; m_d0[c] = d; m_p0[c] = p;
      m_sw[c] = NEVER; m_en[c] = en;
      if (en) m_st[c] = m + 1;
   endtask

   task automatic set_ch_en(input int c, input bit en);
      int m;
      wr(8'(c * 16), 32'((m_pre[c] << 2) | int'(en)), m);
      m_en[c] = en;
      m_sw[c] = NEVER;
      if (en) m_st[c] = m + 1;
   endtask

   task automatic set_master(input bit v);
      int m;
      wr(8'h3C, 32'(v), m);
      m_mst = v;
      if (v) for (int c = 0; c < NCH; c++) begin
         if (m_en[c]) begin m_st[c] = m + 1; m_sw[c] = NEVER; end
      end
   endtask

   // monitor side of the scoreboard
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].cyc < cyc) begin
         check({q[0].tag, " missed sample"}, 32'd1, 32'd0);
         void'(q.pop_front());
      end
      if (q.size() > 0 && q[0].cyc == cyc) begin
         check(q[0].tag, {28'd0, pwm}, {28'd0, q[0].vec});
         void'(q.pop_front());
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      int m, mw, kk_u, len;
      for (int c = 0; c < NCH; c++) begin
         m_pre[c] = 0; m_d0[c] = 0; m_p0[c] = 0; m_d1[c] = 0; m_p1[c] = 0;
         m_st[c] = 0; m_sw[c] = NEVER; m_en[c] = 1'b0;
      end
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1: reset state
      for (int c = 0; c < NCH; c++) begin
         rd_check(8'(c*16),     32'h0, "R1 ctrl");
         rd_check(8'(c*16 + 4), 32'h0, "R1 duty");
         rd_check(8'(c*16 + 8), 32'h0, "R1 period");
      end
      rd_check(8'h3C, 32'h0, "R1 master");
      check("R1 outputs", {28'd0, pwm}, 32'h0);

      // R2: map, field masks, unused addresses
      wr(8'h14, 32'h1234_5678, m);  rd_check(8'h14, 32'h0000_5678, "R2 duty ch1");
      wr(8'h18, 32'hFFFF_ABCD, m);  rd_check(8'h18, 32'h0000_ABCD, "R2 period ch1");
      wr(8'h20, 32'hFFFF_FFFF, m);  rd_check(8'h20, 32'h0000_FFFD, "R2 ctrl ch2");
      wr(8'h3C, 32'hFFFF_FFFE, m);  rd_check(8'h3C, 32'h0, "R2 master bit0 clear");
      wr(8'h3C, 32'h0000_0003, m);  rd_check(8'h3C, 32'h1, "R2 master bit0 set");
      wr(8'h0C, 32'hFFFF_FFFF, m);  rd_check(8'h0C, 32'h0, "R2 unused offset");
      rd_check(8'h2C, 32'h0, "R2 unused offset ch2");
      rd_check(8'h14, 32'h0000_5678, "R2 duty ch1 kept");
      check("R3 duty zero stays low", {28'd0, pwm}, 32'h0);
      wr(8'h14, 32'h0, m); wr(8'h18, 32'h0, m); wr(8'h20, 32'h0, m); wr(8'h3C, 32'h0, m);

      // R5: channel enabled, master off
      cfg_ch(0, 0, 3, 8, 1'b1);
      expect_span(cyc, 12, "R5 master off");
      drain();
      // R6: master on, no channel enabled
      set_ch_en(0, 1'b0);
      set_master(1'b1);
      expect_span(cyc, 12, "R6 master only");
      drain();
      set_master(1'b0);

      // R3 and R9: two channels started together
      cfg_ch(0, 0, 3, 8, 1'b1);
      cfg_ch(1, 2, 1, 3, 1'b1);
      set_master(1'b1);
      expect_span(cyc, 48, "R3/R9 two channels");
      drain();

      // R4: duty above period and duty equal to period
      cfg_ch(2, 1, 7, 4, 1'b1);
      cfg_ch(3, 0, 5, 5, 1'b1);
      expect_span(cyc, 24, "R4 full high");
      drain();

      // R7: channel disable and restart
      set_ch_en(0, 1'b0);
      expect_span(cyc, 10, "R7 ch0 stopped");
      drain();
      set_ch_en(0, 1'b1);
      expect_span(cyc, 16, "R7 ch0 restart");
      drain();
      // R7: master disable resets every channel
      set_master(1'b0);
      expect_span(cyc, 6, "R5 master cleared");
      drain();
      set_master(1'b1);
      expect_span(cyc, 30, "R7 all restart");
      drain();

      // R8: update of duty and period mid-period
      set_ch_en(3, 1'b0);
      cfg_ch(3, 1, 2, 6, 1'b1);
      wr(8'h34, 32'd1, mw);
      wr(8'h38, 32'd3, mw);
      len  = 2 * 6;
      kk_u = (mw + 1) - m_st[3];
      m_d1[3] = 1; m_p1[3] = 3;
      m_sw[3] = (kk_u / len + 1) * len;
      expect_span(cyc, 40, "R8 boundary update");
      drain();

      summary();
   end
endmodule